// File: doc/BRIEF.md
# Serial Memory Request Target Bridge

This block terminates a one-bit serial request link and turns each packet into one parallel memory access. Every 64-bit word on the link is framed by a one-cycle valid strobe that lines up with the word's least significant bit. The other 63 bits follow on the next 63 cycles. The first word is a header that holds a command byte, a reserved field and a physical address. A write header is followed by a second framed word that carries the write data. A read header stands alone.

Once a packet is decoded, the bridge raises a request on a simple synchronous memory port. It holds that request until the memory answers ready. It then sends a reply on a one-bit serial response link: a one-cycle response strobe followed by a 64-cycle packet. For a read, the packet carries the returned data. For a write, the packet is an acknowledge with the data line held low throughout. Only one request is handled at a time. A malformed header is dropped and raises a sticky error flag.

Top module: `srq_target_bridge`

## Requirements
- R1: A request starts when `req_vld_i` is high in an idle cycle. `req_dat_i` then supplies header bit 0 in that cycle and bits 1 to 63 on the following cycles. The command byte is header bits [63:56] and the physical address is header bits [39:0]. The address is presented unchanged on `mem_addr_o`.
- R2: Command 0x82 is a write. The next `req_vld_i` pulse starts the write data word, LSB first over 64 cycles, and idle cycles may come before that pulse. The word is presented on `mem_wdata_o` with `mem_we_o` = 1.
- R3: Command 0x81 is a read and has no data word. `mem_req_o` rises with `mem_we_o` = 0 in the cycle after the last header bit.
- R4: `mem_req_o` rises in the cycle after the final request bit. It stays high, with address, write enable and write data stable, up to and including the first cycle in which `mem_rdy_i` is high. It then falls, giving exactly one transfer per request.
- R5: After a write completes, `rsp_vld_o` is high for exactly one cycle and starts a 64-cycle acknowledge packet. `rsp_dat_o` stays 0 throughout that packet.
- R6: After a read completes, `rsp_vld_o` is high for one cycle and carries bit 0 of the read data on `rsp_dat_o` in that same cycle. Bits 1 to 63 follow on the next 63 cycles.
- R7: `rsp_dat_o` is 0 in every cycle in which no read data bit is being sent.
- R8: The response strobe comes no sooner than 3 cycles after the final request bit. If the final bit is in cycle N and the memory is ready after D wait cycles, `rsp_vld_o` is high in cycle N+3+D.
- R9: A header whose command is neither 0x81 nor 0x82, or whose reserved bits [55:40] are not all zero, causes no memory access and no response. It sets `err_o` from the next cycle until reset.
- R10: A `req_vld_i` pulse is ignored while the memory access, the response wait or the response packet is in progress. A new request is accepted in the cycle right after the last response bit.
- R11: During reset, `mem_req_o`, `rsp_vld_o`, `rsp_dat_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Word-start strobe of the serial request link |
| req_dat_i | input | 1 | Serial request data, LSB first |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W (40) | Physical address of the access |
| mem_wdata_o | output | WORD_W (64) | Write data |
| mem_rdy_i | input | 1 | Memory accepts and completes the access this cycle |
| mem_rdata_i | input | WORD_W (64) | Read data, valid with `mem_rdy_i` |
| rsp_vld_o | output | 1 | One-cycle start strobe of the response packet |
| rsp_dat_o | output | 1 | Serial response data, LSB first |
| err_o | output | 1 | Sticky malformed-header flag |

## Verification
The bench sends write packets with and without idle cycles before the data word. A bridge that expects the data word right after the header would misread those bits or stall. Memory latencies of zero and several cycles are used. A bridge that counts the response gap from the memory handshake instead of the final request bit, or that drops the request before ready, would move the reply strobe or make a second transfer. Stray strobes are injected during the memory wait and during the reply, and the next request starts directly after the last reply bit. These expose a bridge that re-arms too early or too late. Headers with a bad command and with reserved bits set must leave the memory port and the reply line silent while the error flag latches.

// File: rtl/srq_pkg.sv
`timescale 1ns/1ps
package srq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WAIT,
    ST_WDAT,
    ST_MEM,
    ST_GAP,
    ST_RSP
  } srq_state_e;

endpackage

// File: rtl/srq_rx_deser.sv
`timescale 1ns/1ps
module srq_rx_deser #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         din_i,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             step;

  assign step   = start_i | run_q;
  assign done_o = step && (cnt_q == LAST);
  assign word_o = {din_i, sh_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (step) begin
      sh_q <= word_o;
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        run_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srq_hdr_decode.sv
`timescale 1ns/1ps
module srq_hdr_decode #(
  parameter int         W      = 64,
  parameter int         ADDR_W = 40,
  parameter logic [7:0] CMD_WR = 8'h82,
  parameter logic [7:0] CMD_RD = 8'h81
) (
  input  logic [W-1:0]      hdr_i,
  output logic              is_wr_o,
  output logic              is_rd_o,
  output logic              bad_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CMD_LSB = W - 8;
  localparam int RSV_W   = CMD_LSB - ADDR_W;

  function automatic logic [7:0] hdr_cmd(input logic [W-1:0] h);
    return h[W-1:CMD_LSB];
  endfunction

  function automatic logic hdr_rsv_clear(input logic [W-1:0] h);
    return h[CMD_LSB-1:ADDR_W] == {RSV_W{1'b0}};
  endfunction

  logic [7:0] cmd;
  logic       rsv_ok;

  assign cmd     = hdr_cmd(hdr_i);
  assign rsv_ok  = hdr_rsv_clear(hdr_i);
  assign is_wr_o = rsv_ok && (cmd == CMD_WR);
  assign is_rd_o = rsv_ok && (cmd == CMD_RD);
  assign bad_o   = !(is_wr_o || is_rd_o);
  assign addr_o  = hdr_i[ADDR_W-1:0];
endmodule

// File: rtl/srq_rsp_ser.sv
`timescale 1ns/1ps
module srq_rsp_ser #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         rd_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic         dat_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             first_q;
  logic             rd_q;

  assign vld_o  = run_q & first_q;
  assign dat_o  = run_q & rd_q & sh_q[0];
  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
    end else if (start_i) begin
      sh_q    <= data_i;
      cnt_q   <= '0;
      run_q   <= 1'b1;
      first_q <= 1'b1;
      rd_q    <= rd_i;
    end else if (run_q) begin
      first_q <= 1'b0;
      sh_q    <= sh_q >> 1;
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        rd_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srq_target_bridge.sv
`timescale 1ns/1ps
module srq_target_bridge #(
  parameter int         WORD_W  = 64,
  parameter int         ADDR_W  = 40,
  parameter logic [7:0] CMD_WR  = 8'h82,
  parameter logic [7:0] CMD_RD  = 8'h81,
  parameter int         RSP_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld_i,
  input  logic              req_dat_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rdy_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rsp_vld_o,
  output logic              rsp_dat_o,
  output logic              err_o
);
  import srq_pkg::*;

  localparam int LAT_W = $clog2(RSP_GAP + 1);
  localparam logic [LAT_W-1:0] LAT_MAX = LAT_W'(RSP_GAP);
  localparam logic [LAT_W-1:0] LAT_GO  = LAT_W'(RSP_GAP - 1);

  srq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;
  logic [LAT_W-1:0]  lat_q;

  // Named internal events, also observed by the bound checker
  logic              deser_start;
  logic              deser_done;
  logic [WORD_W-1:0] deser_word;
  logic              dec_wr, dec_rd, dec_bad;
  logic [ADDR_W-1:0] dec_addr;
  logic              hdr_done;
  logic              hdr_bad_evt;
  logic              req_last;
  logic              mem_fire;
  logic              gap_ok;
  logic              rsp_start;
  logic              rsp_busy;
  logic              rsp_done;

  assign deser_start = req_vld_i && !rsp_busy &&
                       (state_q == ST_IDLE || state_q == ST_WAIT);

  srq_rx_deser #(.W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (deser_start),
    .din_i   (req_dat_i),
    .done_o  (deser_done),
    .word_o  (deser_word)
  );

  srq_hdr_decode #(
    .W      (WORD_W),
    .ADDR_W (ADDR_W),
    .CMD_WR (CMD_WR),
    .CMD_RD (CMD_RD)
  ) u_dec (
    .hdr_i   (deser_word),
    .is_wr_o (dec_wr),
    .is_rd_o (dec_rd),
    .bad_o   (dec_bad),
    .addr_o  (dec_addr)
  );

  assign hdr_done    = (state_q == ST_HDR) && deser_done;
  assign hdr_bad_evt = hdr_done && dec_bad;
  assign req_last    = (hdr_done && dec_rd) || ((state_q == ST_WDAT) && deser_done);
  assign mem_fire    = (state_q == ST_MEM) && mem_rdy_i;
  assign gap_ok      = lat_q >= LAT_GO;
  assign rsp_start   = (state_q == ST_GAP) && gap_ok;

  srq_rsp_ser #(.W(WORD_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rsp_start),
    .rd_i    (!we_q),
    .data_i  (rdata_q),
    .vld_o   (rsp_vld_o),
    .dat_o   (rsp_dat_o),
    .busy_o  (rsp_busy),
    .done_o  (rsp_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (deser_start) state_d = ST_HDR;
      ST_HDR: begin
        if (hdr_done) begin
          if (dec_wr)      state_d = ST_WAIT;
          else if (dec_rd) state_d = ST_MEM;
          else             state_d = ST_IDLE;
        end
      end
      ST_WAIT: if (deser_start) state_d = ST_WDAT;
      ST_WDAT: if (deser_done) state_d = ST_MEM;
      ST_MEM:  if (mem_rdy_i) state_d = ST_GAP;
      ST_GAP:  if (gap_ok) state_d = ST_RSP;
      ST_RSP:  if (rsp_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      lat_q   <= LAT_MAX;
    end else begin
      state_q <= state_d;
      if (hdr_done && !dec_bad) begin
        addr_q <= dec_addr;
        we_q   <= dec_wr;
      end
      if ((state_q == ST_WDAT) && deser_done) wdata_q <= deser_word;
      if (mem_fire && !we_q) rdata_q <= mem_rdata_i;
      if (hdr_bad_evt) err_q <= 1'b1;
      if (req_last)             lat_q <= LAT_W'(1);
      else if (lat_q != LAT_MAX) lat_q <= lat_q + 1'b1;
    end
  end

  assign mem_req_o   = (state_q == ST_MEM);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign err_o       = err_q;
endmodule

// File: rtl/srq_target_bridge_chk.sv
`timescale 1ns/1ps
module srq_target_bridge_chk #(
  parameter int ADDR_W  = 40,
  parameter int WORD_W  = 64,
  parameter int RSP_GAP = 3,
  parameter int LAT_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_rdy_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              rsp_vld_o,
  input logic              rsp_dat_o,
  input logic              err_o,
  input logic              rsp_busy,
  input logic              we_q,
  input logic [LAT_W-1:0]  lat_q,
  input logic              hdr_bad_evt
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_req_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> !mem_req_o);

  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o |=> !rsp_vld_o);

  p_dat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_busy || we_q) |-> !rsp_dat_o);

  p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld_o |-> (lat_q >= LAT_W'(RSP_GAP)));

  p_bad_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad_evt |=> (!mem_req_o && !rsp_busy && err_o));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  p_one_at_a_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !rsp_busy);
endmodule

bind srq_target_bridge srq_target_bridge_chk #(
  .ADDR_W  (ADDR_W),
  .WORD_W  (WORD_W),
  .RSP_GAP (RSP_GAP),
  .LAT_W   (LAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_rdy_i   (mem_rdy_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rsp_vld_o   (rsp_vld_o),
  .rsp_dat_o   (rsp_dat_o),
  .err_o       (err_o),
  .rsp_busy    (rsp_busy),
  .we_q        (we_q),
  .lat_q       (lat_q),
  .hdr_bad_evt (hdr_bad_evt)
);

// File: tb/srq_target_bridge_tb.sv
`timescale 1ns/1ps
module srq_target_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld_i = 1'b0;
  logic        req_dat_i = 1'b0;
  logic        mem_req_o, mem_we_o, mem_rdy_i;
  logic [39:0] mem_addr_o;
  logic [63:0] mem_wdata_o, mem_rdata_i;
  logic        rsp_vld_o, rsp_dat_o, err_o;

  srq_target_bridge u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld_i   (req_vld_i),
    .req_dat_i   (req_dat_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdy_i   (mem_rdy_i),
    .mem_rdata_i (mem_rdata_i),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_dat_o   (rsp_dat_o),
    .err_o       (err_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit ended = 1'b0;
  int err_from = 32'h7fff_ffff;
  int mem_delay = 0;
  int wait_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state: expected per-cycle outputs and expected transfers
  bit exp_v[int];
  bit exp_d[int];
  bit exp_r[int];
  typedef struct { logic [39:0] a; bit we; logic [63:0] d; } xact_t;
  xact_t xq[$];

  function automatic logic [63:0] mem_pat(input logic [39:0] a);
    return {a[31:0] ^ 32'hA5C3_0F96, a[39:8]};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", r, cyc, act, exp);
    end
  endtask

  // Memory model: ready after mem_delay wait cycles
  assign mem_rdy_i   = mem_req_o && (wait_cnt == mem_delay);
  assign mem_rdata_i = mem_pat(mem_addr_o);

  always @(posedge clk) begin
    if (!mem_req_o || mem_rdy_i) wait_cnt <= 0;
    else                         wait_cnt <= wait_cnt + 1;
    if (rst_n && mem_req_o && mem_rdy_i) begin
      if (xq.size() == 0) begin
        chk(1'b0, "R4 unexpected transfer", {24'h0, mem_addr_o}, 64'h0);
      end else begin
        xact_t x;
        x = xq.pop_front();
        chk(mem_addr_o === x.a, "R1 address", {24'h0, mem_addr_o}, {24'h0, x.a});
        chk(mem_we_o === x.we, x.we ? "R2 write enable" : "R3 read enable",
            {63'h0, mem_we_o}, {63'h0, x.we});
        if (x.we) chk(mem_wdata_o === x.d, "R2 write data", mem_wdata_o, x.d);
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !ended) begin
      bit ev, ed, er, ee;
      ev = exp_v.exists(cyc);
      ed = exp_d.exists(cyc) ? exp_d[cyc] : 1'b0;
      er = exp_r.exists(cyc);
      ee = (cyc >= err_from);
      chk(rsp_vld_o === ev, "R8 response strobe timing", {63'h0, rsp_vld_o}, {63'h0, ev});
      chk(rsp_dat_o === ed, "R7 response data line", {63'h0, rsp_dat_o}, {63'h0, ed});
      chk(mem_req_o === er, "R4 request window", {63'h0, mem_req_o}, {63'h0, er});
      chk(err_o === ee, "R9 error flag", {63'h0, err_o}, {63'h0, ee});
    end
  end

  task automatic drive(input bit v, input bit d);
    @(posedge clk) #1;
    req_vld_i = v;
    req_dat_i = d;
  endtask

  task automatic send(input logic [7:0] cmd, input logic [15:0] rsv, input logic [39:0] addr,
                      input logic [63:0] wd, input int gap, input int dly, input bit noise);
    logic [63:0] hdr, pat;
    bit good, wr;
    int f, st, last;
    hdr  = {cmd, rsv, addr};
    good = ((cmd == 8'h82) || (cmd == 8'h81)) && (rsv == 16'h0);
    wr   = (cmd == 8'h82);
    pat  = mem_pat(addr);
    mem_delay = dly;
    for (int i = 0; i < 64; i++) drive(i == 0, hdr[i]);
    f = cyc;
    if (good && wr) begin
      for (int g = 0; g < gap; g++) drive(1'b0, 1'b0);
      for (int i = 0; i < 64; i++) drive(i == 0, wd[i]);
      f = cyc;
    end
    if (!good) begin
      if (err_from > f + 1) err_from = f + 1;
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b0);
      return;
    end
    xq.push_back('{addr, wr, wd});
    for (int c = f + 1; c <= f + 1 + dly; c++) exp_r[c] = 1'b1;
    st = f + 3 + dly;
    last = st + 63;
    exp_v[st] = 1'b1;
    if (!wr) for (int k = 0; k < 64; k++) exp_d[st + k] = pat[k];
    while (cyc < last) begin
      // R10: stray strobes while busy must be ignored
      bit nz;
      nz = noise && ((cyc + 1 == f + 1) || ((cyc + 1 >= st + 8) && (cyc + 1 <= st + 11)));
      drive(nz, nz);
      if (cyc == st) begin
        #4;
        chk(rsp_vld_o === 1'b1, wr ? "R5 acknowledge strobe" : "R6 read strobe",
            {63'h0, rsp_vld_o}, 64'h1);
        chk(rsp_dat_o === (wr ? 1'b0 : pat[0]), wr ? "R5 acknowledge data" : "R6 read bit 0",
            {63'h0, rsp_dat_o}, {63'h0, (wr ? 1'b0 : pat[0])});
      end
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R11: reset state
    chk({mem_req_o, rsp_vld_o, rsp_dat_o, err_o} === 4'b0000, "R11 reset outputs",
        {60'h0, mem_req_o, rsp_vld_o, rsp_dat_o, err_o}, 64'h0);
    @(posedge clk) #1;
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (2) drive(1'b0, 1'b0);

    send(8'h81, 16'h0, 40'h12_3456_7808, 64'h0, 0, 0, 1'b0);                     // R3, R6, R8
    send(8'h82, 16'h0, 40'hAB_CDEF_0010, 64'hDEAD_BEEF_0123_4567, 0, 0, 1'b0);   // R2, R5
    send(8'h82, 16'h0, 40'h00_0000_0FF8, 64'h8000_0000_0000_0001, 5, 3, 1'b0);   // R2 gap, R8 latency
    send(8'h81, 16'h0, 40'hFF_FFFF_FFF8, 64'h0, 0, 4, 1'b1);                     // R10 stray strobes
    send(8'h82, 16'h0, 40'h55_5555_5550, 64'hFFFF_FFFF_FFFF_FFFF, 2, 1, 1'b1);   // R10 on write
    send(8'h83, 16'h0, 40'h11_1111_1110, 64'h0, 0, 0, 1'b0);                     // R9 bad command
    send(8'h81, 16'h0, 40'h0A_0B0C_0D08, 64'h0, 0, 2, 1'b0);                     // works after error
    send(8'h81, 16'h0010, 40'h22_2222_2220, 64'h0, 0, 0, 1'b0);                  // R9 reserved bits
    send(8'h82, 16'h8000, 40'h33_3333_3330, 64'h1234, 0, 0, 1'b0);               // R9 reserved on write
    send(8'h81, 16'h0, 40'h00_0000_0000, 64'h0, 0, 0, 1'b0);                     // R1 zero address

    repeat (6) drive(1'b0, 1'b0);
    chk(xq.size() == 0, "R10 every accepted request transferred once",
        64'(xq.size()), 64'h0);
    finish_run();
  end
endmodule